// File: doc/BRIEF.md
# Two-Level Core Interrupt Sequencer

This block stands between the interrupt sources of a chip and a simple in-order processor pipeline, and decides when the core takes an interrupt. There are two request levels. The normal level is gated by the external-enable bit of the machine state register. The critical level has its own line and is gated by its own critical-enable bit. Both request lines are level-sensitive and may change at any time relative to the core clock, so each passes through a two-flop synchronizer first. When both levels are pending and enabled, the critical level wins.

Taking an interrupt is a short sequence. The block raises three kill lines: one for multi-cycle operations that have not completed, one for outstanding loads and stores, and one for a page-table walk in progress. It waits for the pipeline to report that the flush is done. It then saves the program counter and the two enable bits into the save bank of that level. One cycle later it redirects fetch to the fixed vector of that level and writes the new enable bits back to the state register.

Each level has its own save bank and its own return strobe. A critical interrupt can therefore be taken inside a normal handler, and the two returns unwind in order.

Top module: `irq_two_level_seq`

## Requirements
- R1: Each request line passes through two synchronizer flops and a decision register. A request driven between clock edges makes `kill_o` nonzero just after the third following rising edge, and not before.
- R2: A normal request is accepted only while `msr_ee_i` is 1. While `msr_ee_i` is 0 the request has no effect and produces no kill.
- R3: Requests are not stored. A request that drops before it is accepted has no later effect, even after its enable is set.
- R4: A critical request is accepted whenever `msr_ce_i` is 1, whatever the value of `msr_ee_i`.
- R5: When both requests are accepted in the same cycle, the critical one is taken. A normal line that is still held high is taken after the critical return restores `msr_ee_i`.
- R6: While a flush is pending, `kill_o` is 3'b111 and stays there until `flush_done_i` is sampled high. Bit 0 kills multi-cycle operations, bit 1 kills outstanding loads and stores, and bit 2 kills a table walk. Outside a flush, `kill_o` is 3'b000.
- R7: One cycle after `flush_done_i` is sampled high, `redirect_o` is 1 for exactly one cycle, and in that cycle `kill_o` is 0.
- R8: Entry redirects go to 0x00A00 for the critical level and to 0x00500 for the normal level.
- R9: On entry, `msr_wr_o` is 1 and `msr_ee_o` is 0. For a critical entry `msr_ce_o` is 0. For a normal entry `msr_ce_o` keeps the value of the critical-enable bit at acceptance. The saved return address is `pc_i` in the cycle where `flush_done_i` is sampled.
- R10: `ret_crit_i` redirects to the address in the critical save bank and writes back the enable bits saved there. `ret_norm_i` does the same from the normal save bank. The two banks are independent, so nested entries unwind correctly.
- R11: After reset, `kill_o`, `redirect_o` and `msr_wr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| norm_req_i | input | 1 | Normal interrupt request, level-sensitive, asynchronous |
| crit_req_i | input | 1 | Critical interrupt request, level-sensitive, asynchronous |
| msr_ee_i | input | 1 | External-enable bit of the state register |
| msr_ce_i | input | 1 | Critical-enable bit of the state register |
| pc_i | input | PC_W | Current program counter from the pipeline |
| ret_norm_i | input | 1 | Return-from-normal-interrupt strobe |
| ret_crit_i | input | 1 | Return-from-critical-interrupt strobe |
| flush_done_i | input | 1 | Pipeline acknowledges that the killed work is gone |
| kill_o | output | 3 | Kill lines: bit 0 multi-cycle, bit 1 load/store, bit 2 table walk |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | PC_W | Fetch target while `redirect_o` is 1 |
| msr_wr_o | output | 1 | Write strobe for the two enable bits |
| msr_ee_o | output | 1 | New external-enable value |
| msr_ce_o | output | 1 | New critical-enable value |

## Verification
The bench raises both lines together and checks that the vector is 0x00A00. A design without the priority would jump to 0x00500 instead. It then confirms that the normal line, still held high, is taken only after the critical return. The bench also holds a normal request high while the external enable is clear, drops it, and then sets the enable. A design that stored the request would raise the kill lines at that point.

A normal handler is interrupted by a critical one, and the two returns are unwound in order. A shared save bank would send the second return to the wrong address. Every sequence is checked cycle by cycle against the three-edge acceptance latency and the one-cycle gap between the flush acknowledge and the redirect. Randomly drawn enables, requests and flush delays are mixed with these directed cases.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FLUSH  = 2'd1,
    ST_ENTER  = 2'd2,
    ST_RETURN = 2'd3
  } seq_state_e;

  typedef enum logic {
    LVL_NORM = 1'b0,
    LVL_CRIT = 1'b1
  } irq_lvl_e;

  typedef struct packed {
    logic ce;
    logic ee;
  } en_bits_t;

  localparam int unsigned NUM_LVL   = 2;
  localparam int unsigned KILL_W    = 3;
  localparam int unsigned KILL_MULTI = 0;
  localparam int unsigned KILL_LDST  = 1;
  localparam int unsigned KILL_WALK  = 2;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     idle_i,
  input  logic     nreq_i,
  input  logic     creq_i,
  input  en_bits_t en_i,
  input  logic     ret_norm_i,
  input  logic     ret_crit_i,
  output logic     take_o,
  output irq_lvl_e take_lvl_o,
  output logic     ret_o,
  output irq_lvl_e ret_lvl_o
);

  logic crit_ok;
  logic norm_ok;
  logic ret_any;

  always_comb begin
    crit_ok    = creq_i & en_i.ce;
    norm_ok    = nreq_i & en_i.ee;
    ret_any    = ret_norm_i | ret_crit_i;
    ret_o      = idle_i & ret_any;
    ret_lvl_o  = ret_crit_i ? LVL_CRIT : LVL_NORM;
    take_o     = idle_i & ~ret_any & (crit_ok | norm_ok);
    take_lvl_o = crit_ok ? LVL_CRIT : LVL_NORM;
  end

  // R2: a normal grant needs the external enable
  p_norm_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_lvl_o == LVL_NORM) |-> en_i.ee);

  // R4: a critical grant needs only the critical enable
  p_crit_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_lvl_o == LVL_CRIT) |-> (creq_i && en_i.ce));

  // R5: an enabled critical request is never passed over
  p_crit_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && creq_i && en_i.ce) |-> (take_lvl_o == LVL_CRIT));

endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank
  import irq_seq_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_i,
  input  logic [PC_W-1:0] pc_i,
  input  en_bits_t        bits_i,
  output logic [PC_W-1:0] pc_o,
  output en_bits_t        bits_o
);

  logic [PC_W-1:0] pc_q, pc_d;
  en_bits_t        bits_q, bits_d;

  always_comb begin
    pc_d   = save_i ? pc_i   : pc_q;
    bits_d = save_i ? bits_i : bits_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      bits_q <= '0;
    end else begin
      pc_q   <= pc_d;
      bits_q <= bits_d;
    end
  end

  assign pc_o   = pc_q;
  assign bits_o = bits_q;

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int unsigned     PC_W     = 32,
  parameter logic [PC_W-1:0] VEC_NORM = 'h500,
  parameter logic [PC_W-1:0] VEC_CRIT = 'hA00
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           take_i,
  input  irq_lvl_e                       take_lvl_i,
  input  logic                           ret_i,
  input  irq_lvl_e                       ret_lvl_i,
  input  en_bits_t                       en_i,
  input  logic                           flush_done_i,
  input  logic [NUM_LVL-1:0][PC_W-1:0]   bank_pc_i,
  input  en_bits_t [NUM_LVL-1:0]         bank_bits_i,
  output logic                           idle_o,
  output logic [NUM_LVL-1:0]             save_o,
  output en_bits_t                       save_bits_o,
  output logic [KILL_W-1:0]              kill_o,
  output logic                           redirect_o,
  output logic [PC_W-1:0]                redirect_pc_o,
  output logic                           msr_wr_o,
  output logic                           msr_ee_o,
  output logic                           msr_ce_o
);

  seq_state_e state_q, state_d;
  irq_lvl_e   lvl_q, lvl_d;
  en_bits_t   ent_q, ent_d;
  logic       is_crit;

  // next state
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    ent_d   = ent_q;
    save_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (ret_i) begin
          state_d = ST_RETURN;
          lvl_d   = ret_lvl_i;
        end else if (take_i) begin
          state_d = ST_FLUSH;
          lvl_d   = take_lvl_i;
          ent_d   = en_i;
        end
      end
      ST_FLUSH: begin
        if (flush_done_i) begin
          state_d             = ST_ENTER;
          save_o[int'(lvl_q)] = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= LVL_NORM;
      ent_q   <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      ent_q   <= ent_d;
    end
  end

  // outputs decoded from registered state
  always_comb begin
    is_crit     = (lvl_q == LVL_CRIT);
    idle_o      = (state_q == ST_IDLE);
    save_bits_o = ent_q;
    kill_o      = (state_q == ST_FLUSH) ? '1 : '0;
    redirect_o  = (state_q == ST_ENTER) || (state_q == ST_RETURN);
    msr_wr_o    = redirect_o;
    if (state_q == ST_ENTER) begin
      redirect_pc_o = is_crit ? VEC_CRIT : VEC_NORM;
      msr_ee_o      = 1'b0;
      msr_ce_o      = is_crit ? 1'b0 : ent_q.ce;
    end else begin
      redirect_pc_o = bank_pc_i[int'(lvl_q)];
      msr_ee_o      = bank_bits_i[int'(lvl_q)].ee;
      msr_ce_o      = bank_bits_i[int'(lvl_q)].ce;
    end
  end

  // R6: kill lines stay up until the flush is acknowledged
  p_kill_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|kill_o) && !flush_done_i) |=> (&kill_o));

  // R6: the three kill lines move together
  p_kill_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill_o) |-> (&kill_o));

  // R7: redirect follows the acknowledge by one cycle, kills dropped
  p_redir_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|kill_o) && flush_done_i) |=> (redirect_o && kill_o == '0));

  // R7: a redirect lasts one cycle
  p_redir_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o);

endmodule

// File: rtl/irq_two_level_seq.sv
module irq_two_level_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned     PC_W        = 32,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter int unsigned     RST_STAGES  = 2,
  parameter logic [PC_W-1:0] VEC_NORM    = 'h00500,
  parameter logic [PC_W-1:0] VEC_CRIT    = 'h00A00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              norm_req_i,
  input  logic              crit_req_i,
  input  logic              msr_ee_i,
  input  logic              msr_ce_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              ret_norm_i,
  input  logic              ret_crit_i,
  input  logic              flush_done_i,
  output logic [KILL_W-1:0] kill_o,
  output logic              redirect_o,
  output logic [PC_W-1:0]   redirect_pc_o,
  output logic              msr_wr_o,
  output logic              msr_ee_o,
  output logic              msr_ce_o
);

  localparam int unsigned REQ_W = NUM_LVL;

  logic                         rst_int_n;
  logic [REQ_W-1:0]             req_sync;
  en_bits_t                     en;
  logic                         idle;
  logic                         take;
  irq_lvl_e                     take_lvl;
  logic                         ret;
  irq_lvl_e                     ret_lvl;
  logic [NUM_LVL-1:0]           save_v;
  en_bits_t                     save_bits;
  logic [NUM_LVL-1:0][PC_W-1:0] bank_pc;
  en_bits_t [NUM_LVL-1:0]       bank_bits;

  assign en.ee = msr_ee_i;
  assign en.ce = msr_ce_i;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  irq_req_sync #(.W(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({crit_req_i, norm_req_i}),
    .sync_o  (req_sync)
  );

  irq_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .idle_i     (idle),
    .nreq_i     (req_sync[int'(LVL_NORM)]),
    .creq_i     (req_sync[int'(LVL_CRIT)]),
    .en_i       (en),
    .ret_norm_i (ret_norm_i),
    .ret_crit_i (ret_crit_i),
    .take_o     (take),
    .take_lvl_o (take_lvl),
    .ret_o      (ret),
    .ret_lvl_o  (ret_lvl)
  );

  for (genvar gi = 0; gi < NUM_LVL; gi++) begin : g_bank
    irq_save_bank #(.PC_W(PC_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .save_i (save_v[gi]),
      .pc_i   (pc_i),
      .bits_i (save_bits),
      .pc_o   (bank_pc[gi]),
      .bits_o (bank_bits[gi])
    );
  end

  irq_seq_ctrl #(.PC_W(PC_W), .VEC_NORM(VEC_NORM), .VEC_CRIT(VEC_CRIT)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .take_i        (take),
    .take_lvl_i    (take_lvl),
    .ret_i         (ret),
    .ret_lvl_i     (ret_lvl),
    .en_i          (en),
    .flush_done_i  (flush_done_i),
    .bank_pc_i     (bank_pc),
    .bank_bits_i   (bank_bits),
    .idle_o        (idle),
    .save_o        (save_v),
    .save_bits_o   (save_bits),
    .kill_o        (kill_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .msr_wr_o      (msr_wr_o),
    .msr_ee_o      (msr_ee_o),
    .msr_ce_o      (msr_ce_o)
  );

  // R8: an entry redirect targets one of the two vectors
  p_vector_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (redirect_o && $past(|kill_o)) |-> (redirect_pc_o == VEC_NORM || redirect_pc_o == VEC_CRIT));

  // R9: an entry always writes the external enable low
  p_entry_msr_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (redirect_o && $past(|kill_o)) |-> (msr_wr_o && !msr_ee_o));

  // R11: no activity while reset is held
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_int_n |-> (kill_o == '0 && !redirect_o));

endmodule

// File: tb/irq_two_level_seq_tb.sv
module irq_two_level_seq_tb_top;

  localparam int unsigned PC_W = 32;
  localparam logic [31:0] VN = 32'h0000_0500;
  localparam logic [31:0] VC = 32'h0000_0A00;

  logic            clk;
  logic            rst_n;
  logic            norm_req, crit_req;
  logic [PC_W-1:0] pc;
  logic            ret_norm, ret_crit, flush_done;
  logic [2:0]      kill_o;
  logic            redirect_o;
  logic [PC_W-1:0] redirect_pc_o;
  logic            msr_wr_o, msr_ee_o, msr_ce_o;

  // state register model
  logic tb_set, tb_ee, tb_ce;
  logic ee_q, ce_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  irq_two_level_seq #(.PC_W(PC_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .norm_req_i    (norm_req),
    .crit_req_i    (crit_req),
    .msr_ee_i      (ee_q),
    .msr_ce_i      (ce_q),
    .pc_i          (pc),
    .ret_norm_i    (ret_norm),
    .ret_crit_i    (ret_crit),
    .flush_done_i  (flush_done),
    .kill_o        (kill_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .msr_wr_o      (msr_wr_o),
    .msr_ee_o      (msr_ee_o),
    .msr_ce_o      (msr_ce_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      ee_q <= 1'b0;
      ce_q <= 1'b0;
    end else if (msr_wr_o) begin
      ee_q <= msr_ee_o;
      ce_q <= msr_ce_o;
    end else if (tb_set) begin
      ee_q <= tb_ee;
      ce_q <= tb_ce;
    end
  end

  function automatic logic exp_take(logic n, logic c, logic ee, logic ce);
    return (c & ce) | (n & ee);
  endfunction

  function automatic logic exp_crit(logic c, logic ce);
    return c & ce;
  endfunction

  function automatic logic [31:0] exp_vec(logic crit);
    return crit ? VC : VN;
  endfunction

  function automatic logic exp_entry_ce(logic crit, logic ce);
    return crit ? 1'b0 : ce;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_en(input logic ee, input logic ce);
    tb_ee  = ee;
    tb_ce  = ce;
    tb_set = 1'b1;
    step();
    tb_set = 1'b0;
  endtask

  // one take/return transaction; expected values come from the functions above
  task automatic run_txn(input logic n, input logic c, input logic ee, input logic ce,
                         input int dly, input logic [31:0] pcv);
    logic take, crit;
    take = exp_take(n, c, ee, ce);
    crit = exp_crit(c, ce);
    set_en(ee, ce);
    norm_req = n;
    crit_req = c;
    pc       = pcv;
    step();
    step();
    check("R1 no kill before third edge", {29'd0, kill_o}, 32'd0);
    step();
    check("R6 R2 R4 kill after acceptance", {29'd0, kill_o}, take ? 32'd7 : 32'd0);
    if (take) begin
      for (int i = 0; i < dly; i++) begin
        step();
        check("R6 kill held until flush done", {29'd0, kill_o}, 32'd7);
      end
      flush_done = 1'b1;
      step();
      flush_done = 1'b0;
      check("R7 redirect after flush done", {31'd0, redirect_o}, 32'd1);
      check("R7 kill dropped at redirect", {29'd0, kill_o}, 32'd0);
      check("R8 entry vector", redirect_pc_o, exp_vec(crit));
      check("R9 entry msr write", {29'd0, msr_wr_o, msr_ee_o, msr_ce_o},
            {29'd0, 1'b1, 1'b0, exp_entry_ce(crit, ce)});
      step();
      check("R7 redirect one cycle", {31'd0, redirect_o}, 32'd0);
      norm_req = 1'b0;
      crit_req = 1'b0;
      repeat (3) step();
      check("R9 no re-entry while masked", {29'd0, kill_o}, 32'd0);
      if (crit) ret_crit = 1'b1;
      else      ret_norm = 1'b1;
      step();
      ret_crit = 1'b0;
      ret_norm = 1'b0;
      check("R10 return redirect", {31'd0, redirect_o}, 32'd1);
      check("R10 return address", redirect_pc_o, pcv);
      check("R10 restored enables", {30'd0, msr_ee_o, msr_ce_o}, {30'd0, ee, ce});
      step();
      step();
    end else begin
      norm_req = 1'b0;
      crit_req = 1'b0;
    end
    repeat (3) step();
    check("R2 R3 idle after transaction", {29'd0, kill_o}, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int unsigned seed_v;
    rst_n = 1'b0;
    norm_req = 0; crit_req = 0; pc = '0;
    ret_norm = 0; ret_crit = 0; flush_done = 0;
    tb_set = 0; tb_ee = 0; tb_ce = 0;
    seed_v = $urandom(32'h00C0FFEE);
    repeat (3) step();
    check("R11 reset kill", {29'd0, kill_o}, 32'd0);
    check("R11 reset redirect/msr", {30'd0, redirect_o, msr_wr_o}, 32'd0);
    rst_n = 1'b1;
    repeat (5) step();
    check("R11 post-reset idle", {29'd0, kill_o, redirect_o}, 32'd0);

    // R2 R3: masked request ignored, not stored
    set_en(1'b0, 1'b1);
    norm_req = 1'b1;
    repeat (8) step();
    check("R2 masked normal ignored", {29'd0, kill_o}, 32'd0);
    norm_req = 1'b0;
    repeat (3) step();
    set_en(1'b1, 1'b1);
    repeat (4) step();
    check("R3 dropped request not stored", {29'd0, kill_o}, 32'd0);

    // R5: both together, critical wins, normal taken after return
    norm_req = 1'b1; crit_req = 1'b1; pc = 32'h1000;
    repeat (3) step();
    check("R5 kill on dual request", {29'd0, kill_o}, 32'd7);
    flush_done = 1'b1; step(); flush_done = 1'b0;
    check("R5 critical wins vector", redirect_pc_o, VC);
    step();
    crit_req = 1'b0;
    repeat (3) step();
    check("R5 normal held off while EE clear", {29'd0, kill_o}, 32'd0);
    ret_crit = 1'b1; step(); ret_crit = 1'b0;
    check("R10 critical return address", redirect_pc_o, 32'h1000);
    pc = 32'h2000;
    step();
    step();
    check("R5 pending normal taken after return", {29'd0, kill_o}, 32'd7);
    flush_done = 1'b1; step(); flush_done = 1'b0;
    check("R8 normal vector", redirect_pc_o, VN);
    check("R9 normal entry keeps CE", {30'd0, msr_ee_o, msr_ce_o}, 32'd1);
    step();
    norm_req = 1'b0;
    repeat (3) step();
    ret_norm = 1'b1; step(); ret_norm = 1'b0;
    check("R10 normal return address", redirect_pc_o, 32'h2000);
    step(); step();

    // R4 R10: critical nested inside a normal handler
    norm_req = 1'b1; pc = 32'h3000;
    repeat (3) step();
    flush_done = 1'b1; step(); flush_done = 1'b0;
    check("R8 nested outer vector", redirect_pc_o, VN);
    step();
    norm_req = 1'b0;
    repeat (3) step();
    crit_req = 1'b1; pc = 32'h4000;
    repeat (3) step();
    check("R4 critical taken with EE clear", {29'd0, kill_o}, 32'd7);
    flush_done = 1'b1; step(); flush_done = 1'b0;
    check("R9 critical entry clears both", {29'd0, redirect_pc_o == VC, msr_ee_o, msr_ce_o}, 32'd4);
    step();
    crit_req = 1'b0;
    repeat (3) step();
    ret_crit = 1'b1; step(); ret_crit = 1'b0;
    check("R10 inner return address", redirect_pc_o, 32'h4000);
    check("R10 inner restore EE0 CE1", {30'd0, msr_ee_o, msr_ce_o}, 32'd1);
    step(); step();
    ret_norm = 1'b1; step(); ret_norm = 1'b0;
    check("R10 outer return address", redirect_pc_o, 32'h3000);
    check("R10 outer restore EE1 CE1", {30'd0, msr_ee_o, msr_ce_o}, 32'd3);
    step(); step();

    // random transactions
    for (int k = 0; k < 24; k++) begin
      logic n_r, c_r, ee_r, ce_r;
      n_r  = 1'($urandom);
      c_r  = 1'($urandom);
      ee_r = 1'($urandom);
      ce_r = 1'($urandom);
      run_txn(n_r, c_r, ee_r, ce_r, int'($urandom % 6), $urandom & 32'hFFFF_FFFC);
    end

    finish_run();
  end

endmodule